// File: doc/BRIEF.md
# Dual-Clock Watchdog Timer

This block is a watchdog whose counter runs from a dedicated watchdog clock that is separate from the system clock. It therefore keeps counting while the processor's clock is gated in a low-power sleep state. Software keeps it quiet by sending a one-cycle clear pulse in the system domain. If it is not cleared in time, the counter expires. The action taken at expiry depends on the power state that has been synchronized into the watchdog domain. An awake processor receives a watchdog reset request. A sleeping processor receives a wake-up request instead, and no reset.

Every crossing between the two domains uses a handshake or a synchronizer:
- The clear travels as a toggle through a synchronizer.
- The sleep flag passes through two flops.
- Each expiry event comes back as a toggle that the system domain detects by its edge.

The system domain then stretches the chosen request to a fixed number of system cycles. It also records the event in a sticky status flag, and a second bit keeps the kind of the last event.

The timeout length is set by parameters: a counter width and a power-of-two prescaler.

Top module: `wdt_top`

## Requirements
- R1: The counter advances only on `wdtClk`. An expiry happens every 2^(CNT_W+PRESC_LOG2) watchdog cycles after reset or after a clear has taken effect. The count then wraps to zero and keeps running whatever the sleep state is.
- R2: After reset, `wdtReset`, `wakeReq`, `timeoutFlag` and `lastWake` are all 0.
- R3: An expiry while the synchronized sleep flag is 0 drives `wdtReset` to 1 for exactly HOLD_CYC (≥2) system cycles. This starts at the third system edge after the watchdog edge of the expiry. `wakeReq` stays 0.
- R4: An expiry while the synchronized sleep flag is 1 drives `wakeReq` to 1 for exactly HOLD_CYC system cycles, with the same latency as R3. `wdtReset` stays 0.
- R5: A `clearPulse` sampled high at a system edge flips a toggle. The third watchdog edge after that restarts the prescaler and the count from zero, and no expiry happens at that edge.
- R6: `sleeping` is sampled through two watchdog-clock flops before it selects the expiry action.
- R7: `timeoutFlag` is set on every expiry event and stays set until `statusClear` is sampled high. If an event and a clear arrive in the same cycle, the set wins.
- R8: `lastWake` is updated at each event: 1 if that expiry raised a wake-up, 0 if it raised a reset.
- R9: `wdtReset` and `wakeReq` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock |
| sysRstN | input | 1 | System-domain asynchronous reset, active low |
| wdtClk | input | 1 | Dedicated watchdog clock |
| wdtRstN | input | 1 | Watchdog-domain asynchronous reset, active low |
| clearPulse | input | 1 | Software clear, one system cycle high |
| sleeping | input | 1 | Processor is in sleep state |
| statusClear | input | 1 | Clears the sticky timeout flag |
| wdtReset | output | 1 | Watchdog reset request (system domain) |
| wakeReq | output | 1 | Wake-up request (system domain) |
| timeoutFlag | output | 1 | Sticky timeout status |
| lastWake | output | 1 | Kind of last event: 1 wake-up, 0 reset |

## Verification
The counter is first left to expire with the processor awake, and then with it asleep. This separates the reset path from the wake-up path and confirms that sleep stops neither the count nor the wrap. Clear pulses are then sent at intervals shorter than the timeout, which shows that the toggle handshake restarts the count and suppresses every event. The sleep flag is also flipped close to an expiry, so that the two-flop latency decides which request is raised. A cycle-accurate model in the bench follows both clock domains, and every output is compared against it on every system cycle, including the stretch length and the set-wins rule of the sticky flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // strobes from the control into the watchdog-domain datapath
  typedef struct packed {
    logic clr;     // restart prescaler and count
    logic asleep;  // synchronized sleep state
  } wdtCmd_t;

  // expiry event returned by the datapath
  typedef struct packed {
    logic tgl;     // flips once per expiry
    logic kind;    // 1: expiry while asleep
  } wdtEvt_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int PRESC_LOG2 = 2
) (
  input  logic    wdtClk,
  input  logic    wdtRstN,
  input  wdtCmd_t cmd,
  output wdtEvt_t evt
);
  logic [CNT_W-1:0] cnt;
  logic tick;
  logic expire;

  generate
    if (PRESC_LOG2 > 0) begin : g_presc
      logic [PRESC_LOG2-1:0] presc;
      always_ff @(posedge wdtClk or negedge wdtRstN) begin
        if (!wdtRstN)     presc <= '0;
        else if (cmd.clr) presc <= '0;
        else              presc <= presc + 1'b1;
      end
      assign tick = &presc;
    end else begin : g_noPresc
      assign tick = 1'b1;
    end
  endgenerate

  assign expire = tick & (&cnt) & ~cmd.clr;

  always_ff @(posedge wdtClk or negedge wdtRstN) begin
    if (!wdtRstN)     cnt <= '0;
    else if (cmd.clr) cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  always_ff @(posedge wdtClk or negedge wdtRstN) begin
    if (!wdtRstN) begin
      evt <= '0;
    end else if (expire) begin
      evt.tgl  <= ~evt.tgl;
      evt.kind <= cmd.asleep;
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic    sysClk,
  input  logic    sysRstN,
  input  logic    wdtClk,
  input  logic    wdtRstN,
  input  logic    clearPulse,
  input  logic    sleeping,
  input  logic    statusClear,
  output wdtCmd_t cmd,
  input  wdtEvt_t evt,
  output logic    wdtReset,
  output logic    wakeReq,
  output logic    timeoutFlag,
  output logic    lastWake
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  // system domain: clear toggle
  logic clrTgl;
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN)        clrTgl <= 1'b0;
    else if (clearPulse) clrTgl <= ~clrTgl;
  end

  // watchdog domain: clear edge detect and sleep synchronizer
  logic [2:0] clrSync;
  logic [1:0] slpSync;
  always_ff @(posedge wdtClk or negedge wdtRstN) begin
    if (!wdtRstN) begin
      clrSync <= '0;
      slpSync <= '0;
    end else begin
      clrSync <= {clrSync[1:0], clrTgl};
      slpSync <= {slpSync[0], sleeping};
    end
  end
  assign cmd.clr    = clrSync[2] ^ clrSync[1];
  assign cmd.asleep = slpSync[1];

  // system domain: event edge detect, stretch, status
  logic [2:0]    evSync;
  logic          evSys;
  logic [HW-1:0] holdCnt;
  logic          holdKind;

  assign evSys = evSync[2] ^ evSync[1];

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      evSync      <= '0;
      holdCnt     <= '0;
      holdKind    <= 1'b0;
      timeoutFlag <= 1'b0;
      lastWake    <= 1'b0;
    end else begin
      evSync <= {evSync[1:0], evt.tgl};
      if (evSys) begin
        holdCnt     <= HW'(HOLD_CYC);
        holdKind    <= evt.kind;
        timeoutFlag <= 1'b1;
        lastWake    <= evt.kind;
      end else begin
        if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
        if (statusClear)   timeoutFlag <= 1'b0;
      end
    end
  end

  assign wdtReset = (holdCnt != '0) & ~holdKind;
  assign wakeReq  = (holdCnt != '0) &  holdKind;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int PRESC_LOG2 = 2,
  parameter int HOLD_CYC   = 2
) (
  input  logic sysClk,
  input  logic sysRstN,
  input  logic wdtClk,
  input  logic wdtRstN,
  input  logic clearPulse,
  input  logic sleeping,
  input  logic statusClear,
  output logic wdtReset,
  output logic wakeReq,
  output logic timeoutFlag,
  output logic lastWake
);
  wdtCmd_t cmd;
  wdtEvt_t evt;

  wdt_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
    .sysClk(sysClk), .sysRstN(sysRstN), .wdtClk(wdtClk), .wdtRstN(wdtRstN),
    .clearPulse(clearPulse), .sleeping(sleeping), .statusClear(statusClear),
    .cmd(cmd), .evt(evt),
    .wdtReset(wdtReset), .wakeReq(wakeReq),
    .timeoutFlag(timeoutFlag), .lastWake(lastWake)
  );

  wdt_datapath #(.CNT_W(CNT_W), .PRESC_LOG2(PRESC_LOG2)) u_dp (
    .wdtClk(wdtClk), .wdtRstN(wdtRstN), .cmd(cmd), .evt(evt)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk (
  input logic sysClk,
  input logic sysRstN,
  input logic wdtReset,
  input logic wakeReq,
  input logic timeoutFlag,
  input logic lastWake
);
  // R9
  excl_req_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    !(wdtReset && wakeReq));
  // R3
  reset_held_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    $rose(wdtReset) |=> wdtReset);
  // R4
  wake_held_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    $rose(wakeReq) |=> wakeReq);
  // R7
  flag_on_event_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    ($rose(wdtReset) || $rose(wakeReq)) |-> timeoutFlag);
  // R8
  kind_wake_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    $rose(wakeReq) |-> lastWake);
  // R8
  kind_reset_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    $rose(wdtReset) |-> !lastWake);
endmodule

bind wdt_top wdt_chk u_chk (
  .sysClk(sysClk), .sysRstN(sysRstN), .wdtReset(wdtReset),
  .wakeReq(wakeReq), .timeoutFlag(timeoutFlag), .lastWake(lastWake)
);

// File: tb/sim_wdt_top.sv
`timescale 1ns/1ps
module sim_wdt_top;
  localparam int CNT_W = 4, PRESC_LOG2 = 2, HOLD_CYC = 2;
  localparam int TOT = 1 << (CNT_W + PRESC_LOG2);

  logic sysClk, wdtClk, sysRstN, wdtRstN;
  logic clearPulse, sleeping, statusClear;
  logic wdtReset, wakeReq, timeoutFlag, lastWake;

  int checks = 0, errors = 0;
  int resetRises = 0, wakeRises = 0;
  logic prevRst = 0, prevWake = 0;

  wdt_top #(.CNT_W(CNT_W), .PRESC_LOG2(PRESC_LOG2), .HOLD_CYC(HOLD_CYC)) u0 (
    .sysClk(sysClk), .sysRstN(sysRstN), .wdtClk(wdtClk), .wdtRstN(wdtRstN),
    .clearPulse(clearPulse), .sleeping(sleeping), .statusClear(statusClear),
    .wdtReset(wdtReset), .wakeReq(wakeReq),
    .timeoutFlag(timeoutFlag), .lastWake(lastWake)
  );

  initial begin sysClk = 0; forever #5 sysClk = ~sysClk; end
  initial begin
    wdtClk = 0; #2;
    forever begin wdtClk = 1; #20; wdtClk = 0; #20; end
  end

  // behavioural reference model
  int   mAge, mHold;
  logic mClrTgl, mEvTgl, mEvKind, mKind, mFlag, mLast;
  logic [2:0] mClrS, mEvS;
  logic [1:0] mSlS;

  always @(posedge wdtClk or negedge wdtRstN) begin
    if (!wdtRstN) begin
      mAge = 0; mEvTgl = 0; mEvKind = 0; mClrS = 0; mSlS = 0;
    end else begin
      if (mClrS[2] ^ mClrS[1]) mAge = 0;
      else begin
        if (mAge == TOT - 1) begin mEvTgl = ~mEvTgl; mEvKind = mSlS[1]; end
        mAge = (mAge + 1) % TOT;
      end
      mClrS = {mClrS[1:0], mClrTgl};
      mSlS  = {mSlS[0], sleeping};
    end
  end

  always @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      mHold = 0; mKind = 0; mFlag = 0; mLast = 0; mEvS = 0; mClrTgl = 0;
    end else begin
      if (mEvS[2] ^ mEvS[1]) begin
        mHold = HOLD_CYC; mKind = mEvKind; mFlag = 1; mLast = mEvKind;
      end else begin
        if (mHold > 0) mHold--;
        if (statusClear) mFlag = 0;
      end
      mEvS = {mEvS[1:0], mEvTgl};
      if (clearPulse) mClrTgl = ~mClrTgl;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge sysClk) begin
    if (sysRstN) begin
      check("R3 wdtReset", wdtReset, (mHold != 0) && !mKind);
      check("R4 wakeReq", wakeReq, (mHold != 0) && mKind);
      check("R7 timeoutFlag", timeoutFlag, mFlag);
      check("R8 lastWake", lastWake, mLast);
      if (wdtReset && !prevRst) resetRises++;
      if (wakeReq && !prevWake) wakeRises++;
      prevRst = wdtReset; prevWake = wakeReq;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge sysClk);
  endtask

  task automatic count(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    clearPulse = 0; sleeping = 0; statusClear = 0;
    sysRstN = 0; wdtRstN = 0;
    idle(5);
    // R2 reset state
    check("R2 wdtReset", wdtReset, 0);
    check("R2 wakeReq", wakeReq, 0);
    check("R2 timeoutFlag", timeoutFlag, 0);
    check("R2 lastWake", lastWake, 0);
    sysRstN = 1; wdtRstN = 1;

    // R1/R3: awake, let it expire twice (free running wrap)
    idle(560);
    count("R1 R3 reset events awake", resetRises, 2);
    count("R3 no wake awake", wakeRises, 0);

    // R7 clear the sticky flag
    statusClear = 1; idle(1); statusClear = 0; idle(2);
    check("R7 flag cleared", timeoutFlag, 0);

    // R4/R6: asleep, counter keeps running
    resetRises = 0; wakeRises = 0;
    sleeping = 1;
    idle(560);
    count("R4 wake events asleep", wakeRises, 2);
    count("R4 no reset asleep", resetRises, 0);
    check("R8 last was wake", lastWake, 1);

    // R5: periodic clears keep it silent
    sleeping = 0;
    resetRises = 0; wakeRises = 0;
    for (int k = 0; k < 8; k++) begin
      clearPulse = 1; idle(1); clearPulse = 0; idle(120);
    end
    count("R5 no events with clears", resetRises + wakeRises, 0);

    // R6: flip sleep near expiry, model decides the outcome
    for (int k = 0; k < 4; k++) begin
      clearPulse = 1; idle(1); clearPulse = 0;
      idle(250 + k);
      sleeping = ~sleeping;
      idle(40);
    end
    // R7 set wins over a held clear
    statusClear = 1; idle(300); statusClear = 0;
    idle(300);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule